// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This block connects a host processor to a bank of 8-bit configuration registers. The host sees only eight directly addressed ports, selected by a 3-bit port address. It never addresses the bank directly. To reach a bank register, the host first loads a 16-bit index into the index ports. It then reads or writes that register through the data port. The index stays put across data accesses, so several reads and writes can reach one register without loading the index again.

A mode input sets the width of the host bus. In 8-bit mode the index is loaded one byte at a time through two ports. In 16-bit mode one write loads the whole index. Four further ports give the host direct access to a command register, an interrupt flag register and two control registers. The second control register masks the interrupt flags onto a level interrupt output.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the index, every bank register, the command, control 1 and control 2 registers and the interrupt flags are zero, and irq_o is low.
- R2: In 8-bit mode (mode16_i=0), a write to port 0 loads index[7:0] from wdata_i[7:0], and a write to port 1 loads index[15:8] from wdata_i[7:0]. Reads of port 0 and port 1 return index[7:0] and index[15:8] respectively on rdata_o[7:0], with rdata_o[15:8]=0.
- R3: In 16-bit mode (mode16_i=1), a write to port 0 loads all 16 index bits from wdata_i. A read of port 0 returns the full index. Port 1 reads zero, and writes to it are ignored.
- R4: A write to port 2 stores wdata_i[7:0] into the bank register selected by the index. The write takes effect on the rising clock edge where cs_i and wr_i are both high. wdata_i[15:8] is ignored.
- R5: A read of port 2 returns the selected bank register combinationally on rdata_o[7:0], with rdata_o[15:8]=0, in both bus modes.
- R6: The index keeps its value across data-port reads and writes.
- R7: An index of DEPTH or greater reads zero through port 2, and writes to port 2 with such an index change no register.
- R8: Ports 4 (command), 6 (control 1) and 7 (control 2, the interrupt mask) are 8-bit read/write registers. They are addressed directly and are independent of the index.
- R9: Port 5 holds 8 interrupt flags. Flag n sets at a clock edge where irq_evt_i[n] is high. Writing a 1 to bit n of port 5 clears flag n, and writing a 0 leaves it unchanged. If a set and a clear of the same flag fall on the same edge, the set wins. Reads of port 5 return the flags.
- R10: irq_o is high exactly while (flags & control 2) is non-zero.
- R11: Port 3 reads zero and ignores writes. With cs_i low, rdata_o is zero and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 1 selects 16-bit host bus mode, 0 selects 8-bit mode |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe, valid while cs_i is high |
| addr_i | input | 3 | Port address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, combinational from the selected port |
| irq_evt_i | input | 8 | Interrupt event inputs, one per flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the bridge with DEPTH=16. At that size every bank register can be written and read back in both bus modes. For each register, the bench computes the expected value arithmetically from the register number and the pass number. The first out-of-range index, 16, sits right beside the last valid one, so the range limit is tested at its edge along with indices far beyond it. The bench also sweeps every pairing of a single mask bit with a single event bit, which covers the whole interrupt masking matrix.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int HOST_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 16;
  localparam int PORT_W = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_IDX_LO = 3'd0,
    PORT_IDX_HI = 3'd1,
    PORT_DATA   = 3'd2,
    PORT_SPARE  = 3'd3,
    PORT_CMD    = 3'd4,
    PORT_IRQ    = 3'd5,
    PORT_CTL1   = 3'd6,
    PORT_CTL2   = 3'd7
  } port_e;
endpackage

// File: rtl/regwin_index.sv
module regwin_index
  import regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              we_i,
  input  logic [PORT_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (we_i) begin
      if (mode16_i) begin
        if (addr_i == PORT_IDX_LO) idx_q <= wdata_i;
      end else begin
        if (addr_i == PORT_IDX_LO) idx_q[7:0]  <= wdata_i[7:0];
        if (addr_i == PORT_IDX_HI) idx_q[15:8] <= wdata_i[7:0];
      end
    end
  end

  assign idx_o = idx_q;

  p_idx16_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode16_i && addr_i == PORT_IDX_LO) |=> idx_o == $past(wdata_i));

  p_idx_hi_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mode16_i && addr_i == PORT_IDX_HI) |=>
      (idx_o[15:8] == $past(wdata_i[7:0]) && idx_o[7:0] == $past(idx_o[7:0])));
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
  import regwin_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [BYTE_W-1:0] regs_q [DEPTH];
  logic              hit;
  logic [AW-1:0]     sel;

  assign hit = {1'b0, idx_i} < DEPTH_L;
  assign sel = idx_i[AW-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && hit && sel == AW'(g)) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = hit ? regs_q[sel] : '0;

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit) |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq
  import regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic [BYTE_W-1:0] clr_i,
  input  logic [BYTE_W-1:0] mask_i,
  output logic [BYTE_W-1:0] flags_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] flags_q;
  logic [BYTE_W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_mask) | evt_i;  // set wins
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_i);

  p_evt_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && evt_i == '0) |=> ((flags_o & $past(clr_i)) == '0));
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] rdata_o,
  input  logic [BYTE_W-1:0] irq_evt_i,
  output logic              irq_o
);
  logic              we;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] bank_rd, flags;
  logic [BYTE_W-1:0] cmd_q, ctl1_q, ctl2_q;

  assign we = cs_i && wr_i;

  regwin_index u_index (
    .clk_i, .rst_ni, .mode16_i,
    .we_i    (we),
    .addr_i,
    .wdata_i,
    .idx_o   (idx)
  );

  regwin_bank #(.DEPTH(DEPTH)) u_bank (
    .clk_i, .rst_ni,
    .idx_i   (idx),
    .we_i    (we && addr_i == PORT_DATA),
    .wdata_i (wdata_i[BYTE_W-1:0]),
    .rdata_o (bank_rd)
  );

  regwin_irq u_irq (
    .clk_i, .rst_ni,
    .evt_i    (irq_evt_i),
    .clr_we_i (we && addr_i == PORT_IRQ),
    .clr_i    (wdata_i[BYTE_W-1:0]),
    .mask_i   (ctl2_q),
    .flags_o  (flags),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      ctl1_q <= '0;
      ctl2_q <= '0;
    end else if (we) begin
      case (addr_i)
        PORT_CMD:  cmd_q  <= wdata_i[BYTE_W-1:0];
        PORT_CTL1: ctl1_q <= wdata_i[BYTE_W-1:0];
        PORT_CTL2: ctl2_q <= wdata_i[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i) begin
      case (addr_i)
        PORT_IDX_LO: rdata_o = mode16_i ? idx : {8'h00, idx[7:0]};
        PORT_IDX_HI: rdata_o = mode16_i ? '0 : {8'h00, idx[15:8]};
        PORT_DATA:   rdata_o = {8'h00, bank_rd};
        PORT_CMD:    rdata_o = {8'h00, cmd_q};
        PORT_IRQ:    rdata_o = {8'h00, flags};
        PORT_CTL1:   rdata_o = {8'h00, ctl1_q};
        PORT_CTL2:   rdata_o = {8'h00, ctl2_q};
        default:     rdata_o = '0;
      endcase
    end
  end

  p_idx_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr_i == PORT_DATA) |=> $stable(idx));

  p_direct_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr_i == PORT_CTL1) |=> (ctl1_q == $past(wdata_i[BYTE_W-1:0]) && $stable(idx)));
endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
  localparam int DEPTH = 16;

  logic        clk = 0, rst_n = 0, mode16 = 0, cs = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [7:0]  evt = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  exp_bank [DEPTH];

  always #2 clk = ~clk;

  regwin_bridge #(.DEPTH(DEPTH)) u_regwin_bridge (
    .clk_i(clk), .rst_ni(rst_n), .mode16_i(mode16), .cs_i(cs), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_evt_i(evt), .irq_o(irq)
  );

  function automatic logic [7:0] val(int i, int pass);
    return 8'((i * 37 + pass * 11 + 5) & 8'hff);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_port(logic [2:0] a, logic [15:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0; wdata = '0;
  endtask

  task automatic rd_port(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); cs = 1; wr = 0; addr = a;
    #1 d = rdata;
    cs = 0;
  endtask

  task automatic chk_port(string req, logic [2:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd_port(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_idx(logic [15:0] ix);
    if (mode16) wr_port(3'd0, ix);
    else begin
      wr_port(3'd0, {8'h00, ix[7:0]});
      wr_port(3'd1, {8'h00, ix[15:8]});
    end
  endtask

  task automatic pulse_evt(logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int p = 0; p < 8; p++) chk_port("R1", 3'(p), 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    for (int i = 0; i < DEPTH; i++) begin
      set_idx(16'(i));
      chk_port("R1 bank", 3'd2, 16'h0000);
    end

    // R2/R4/R5 8-bit mode sweep
    mode16 = 0;
    for (int i = 0; i < DEPTH; i++) begin
      set_idx(16'(i));
      wr_port(3'd2, {8'hC3, val(i, 1)});
      exp_bank[i] = val(i, 1);
    end
    set_idx(16'hA50B);
    chk_port("R2 lo", 3'd0, 16'h000B);
    chk_port("R2 hi", 3'd1, 16'h00A5);
    for (int i = 0; i < DEPTH; i++) begin
      set_idx(16'(i));
      chk_port("R5 8b", 3'd2, {8'h00, exp_bank[i]});
    end

    // R3/R4/R5 16-bit mode sweep
    mode16 = 1;
    for (int i = 0; i < DEPTH; i++) begin
      set_idx(16'(i));
      chk_port("R3 idx16", 3'd0, 16'(i));
      wr_port(3'd1, 16'hFFFF);
      chk_port("R3 port1", 3'd1, 16'h0000);
      chk_port("R3 port1 ignored", 3'd0, 16'(i));
      wr_port(3'd2, {8'h5A, val(i, 2)});
      exp_bank[i] = val(i, 2);
      chk_port("R4 R5 16b", 3'd2, {8'h00, exp_bank[i]});
    end
    set_idx(16'h1234);
    chk_port("R3 full", 3'd0, 16'h1234);

    // R6 index persistence
    set_idx(16'd3);
    wr_port(3'd2, 16'h0077);
    chk_port("R6 rd1", 3'd2, 16'h0077);
    wr_port(3'd2, 16'h0088);
    chk_port("R6 rd2", 3'd2, 16'h0088);
    chk_port("R6 idx", 3'd0, 16'd3);
    exp_bank[3] = 8'h88;

    // R7 out of range
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ix;
      ix = (k == 0) ? 16'd16 : (k == 1) ? 16'h00FF : (k == 2) ? 16'h0100 : 16'hFFFF;
      set_idx(ix);
      wr_port(3'd2, 16'h00E7);
      chk_port("R7 oob read", 3'd2, 16'h0000);
    end
    for (int i = 0; i < DEPTH; i++) begin
      set_idx(16'(i));
      chk_port("R7 bank intact", 3'd2, {8'h00, exp_bank[i]});
    end

    // R8 direct registers
    set_idx(16'd5);
    wr_port(3'd4, 16'hFF11);
    wr_port(3'd6, 16'h0022);
    wr_port(3'd7, 16'h0000);
    chk_port("R8 cmd", 3'd4, 16'h0011);
    chk_port("R8 ctl1", 3'd6, 16'h0022);
    chk_port("R8 ctl2", 3'd7, 16'h0000);
    chk_port("R8 idx", 3'd0, 16'd5);
    chk_port("R8 bank", 3'd2, {8'h00, exp_bank[5]});

    // R11 spare port and chip select
    wr_port(3'd3, 16'hFFFF);
    chk_port("R11 spare", 3'd3, 16'h0000);
    @(negedge clk); cs = 0; wr = 1; addr = 3'd2; wdata = 16'h00AB;
    @(negedge clk); wr = 0;
    #1 chk("R11 cs low read", rdata, 16'h0000);
    chk_port("R11 no write", 3'd2, {8'h00, exp_bank[5]});

    // R9/R10 interrupt
    wr_port(3'd7, 16'h000F);
    pulse_evt(8'h30);
    chk_port("R9 set", 3'd5, 16'h0030);
    chk("R10 masked", {15'h0, irq}, 16'h0);
    pulse_evt(8'h01);
    chk("R10 asserted", {15'h0, irq}, 16'h1);
    wr_port(3'd5, 16'h0001);
    chk_port("R9 w1c", 3'd5, 16'h0030);
    chk("R10 cleared", {15'h0, irq}, 16'h0);
    @(negedge clk); cs = 1; wr = 1; addr = 3'd5; wdata = 16'h0080; evt = 8'h80;
    @(negedge clk); cs = 0; wr = 0; evt = '0;
    chk_port("R9 set wins", 3'd5, 16'h00B0);
    wr_port(3'd5, 16'h00FF);
    chk_port("R9 clear all", 3'd5, 16'h0000);
    for (int b = 0; b < 8; b++) begin
      wr_port(3'd7, 16'(1 << b));
      for (int j = 0; j < 8; j++) begin
        pulse_evt(8'(1 << j));
        chk("R10 sweep", {15'h0, irq}, {15'h0, b == j});
        wr_port(3'd5, 16'(1 << j));
        chk("R9 sweep clr", {15'h0, irq}, 16'h0);
      end
    end

    finish_run();
  end
endmodule